// File: doc/BRIEF.md
# Consumer-Infrared Transmit Modulator

This block turns bytes from a transmit FIFO into a consumer-infrared output waveform. Each data bit lasts one bit period, which is the time between two pulses of an external bit tick. A one bit is sent as a modulated carrier for the whole period. A zero bit is sent as silence. Bytes made of zeros can therefore pad the gap between packets, with one silent bit period for each zero bit.

The carrier period is split into twelve sub-ticks, which arrive on a separate carrier tick input. A two-bit duty code sets how many of those sub-ticks the carrier stays high. A frame starts only when software sets the start-control bit and the transmit enable and the FIFO holds data. The frame then runs byte after byte until the FIFO is empty at a byte boundary. At that point a one-cycle transmit-status pulse tells software that it can preload the next frame.

Top module: `cir_tx_modulator`

## Requirements
- R1: While and after reset, `irOut`, `fifoRd` and `txDoneIrq` are all low.
- R2: During a one bit, the carrier is high for a number of sub-ticks out of twelve set by `dutySel`: 00 gives 3 (1/4), 01 gives 4 (1/3), 10 gives 5 (5/12) and 11 gives 6 (1/2). The high sub-ticks are sub-ticks 0 up to that count minus one.
- R3: A one bit drives the carrier for its whole bit period, and a zero bit keeps `irOut` low for its whole bit period. A 0x00 byte therefore gives eight silent bit periods.
- R4: The bits of each byte are sent least significant bit first, eight bits per byte.
- R5: When idle, the block pops a byte (`fifoRd` high for one cycle) only if `startCtl`, `txEn` and a non-empty FIFO (`fifoEmpty` low) are all present in the same cycle. Otherwise it does not pop.
- R6: After a byte is loaded at the start of a frame, its first bit begins at the next `bitTick`, and each later `bitTick` moves on to the next bit.
- R7: On the `bitTick` that ends bit 7, if `txEn` is high and the FIFO is not empty, the next byte is popped in that same cycle and its bit 0 follows with no gap.
- R8: On the `bitTick` that ends bit 7, if the FIFO is empty or `txEn` is low, the frame ends. `txDoneIrq` is then high for exactly the one following cycle.
- R9: `irOut` is low whenever no bit is being sent (idle, or loaded and waiting for the first `bitTick`).
- R10: The carrier sub-tick position starts at 0 at reset and moves on by one, modulo twelve, on each `carTick` only. It runs freely whether or not a frame is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | One-cycle pulse marking each bit-period boundary |
| carTick | input | 1 | One-cycle pulse advancing the carrier by one twelfth |
| dutySel | input | 2 | Carrier high-time code |
| startCtl | input | 1 | Software permission to start a frame |
| txEn | input | 1 | Transmit enable |
| fifoEmpty | input | 1 | FIFO holds no data |
| fifoRdata | input | 8 | Head byte of the FIFO (valid while not empty) |
| fifoRd | output | 1 | Pop the head byte of the FIFO |
| irOut | output | 1 | Infrared transmit output |
| txDoneIrq | output | 1 | One-cycle pulse at the end of a frame |

## Verification
Some properties are checked on every cycle. A pop is never issued against an empty FIFO or with transmit disabled. The done pulse is one cycle long, follows a bit tick, and never comes together with a pop. The output never rises outside the sending state. The bench covers the rest through its scenarios. A cycle-level reference model checks the exact carrier shape for every duty code and both carrier tick rates, the LSB-first order, the way bytes run on across boundaries, and the gating by the start and enable bits. An arithmetic total of carrier-high cycles per frame checks the duty fractions independently of that model.

// File: rtl/cir_tx_pkg.sv
package cir_tx_pkg;
  localparam int CAR_SUBS = 12;
  localparam int SUB_W    = $clog2(CAR_SUBS);

  typedef struct packed {
    logic load;     // take head byte, restart bit index
    logic advance;  // move to next bit of current byte
    logic done;     // frame finished
  } cirStrobe_t;

  function automatic logic [SUB_W-1:0] highLen(input logic [1:0] duty);
    return SUB_W'(3) + SUB_W'(duty);
  endfunction
endpackage

// File: rtl/cir_tx_control.sv
module cir_tx_control
  import cir_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       startCtl,
  input  logic       txEn,
  input  logic       fifoEmpty,
  input  logic       bitLast,
  output cirStrobe_t strobe,
  output logic       sending,
  output logic       fifoRd
);
  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_SEND} ctlState_t;
  ctlState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    fifoRd    = 1'b0;
    stateNext = state;
    unique case (state)
      S_IDLE: if (startCtl && txEn && !fifoEmpty) begin
        strobe.load = 1'b1;
        fifoRd      = 1'b1;
        stateNext   = S_ARMED;
      end
      S_ARMED: if (bitTick) stateNext = S_SEND;
      S_SEND: if (bitTick) begin
        if (!bitLast) begin
          strobe.advance = 1'b1;
        end else if (txEn && !fifoEmpty) begin
          strobe.load = 1'b1;
          fifoRd      = 1'b1;
        end else begin
          strobe.done = 1'b1;
          stateNext   = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign sending = (state == S_SEND);
endmodule

// File: rtl/cir_tx_datapath.sv
module cir_tx_datapath
  import cir_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              carTick,
  input  logic [1:0]        dutySel,
  input  logic              sending,
  input  cirStrobe_t        strobe,
  input  logic [DATA_W-1:0] fifoRdata,
  output logic              bitLast,
  output logic              irOut,
  output logic              txDoneIrq
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CAR_SUBS - 1);

  logic [SUB_W-1:0]  subCnt;
  logic [DATA_W-1:0] shiftReg;
  logic [IDX_W-1:0]  bitIdx;
  logic              doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) subCnt <= '0;
    else if (carTick) subCnt <= (subCnt == SUB_LAST) ? '0 : subCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitIdx   <= '0;
    end else if (strobe.load) begin
      shiftReg <= fifoRdata;
      bitIdx   <= '0;
    end else if (strobe.advance) begin
      shiftReg <= shiftReg >> 1;
      bitIdx   <= bitIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= strobe.done;
  end

  assign bitLast   = (bitIdx == IDX_LAST);
  assign irOut     = sending && shiftReg[0] && (subCnt < highLen(dutySel));
  assign txDoneIrq = doneQ;
endmodule

// File: rtl/cir_tx_modulator.sv
module cir_tx_modulator
  import cir_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              carTick,
  input  logic [1:0]        dutySel,
  input  logic              startCtl,
  input  logic              txEn,
  input  logic              fifoEmpty,
  input  logic [DATA_W-1:0] fifoRdata,
  output logic              fifoRd,
  output logic              irOut,
  output logic              txDoneIrq
);
  cirStrobe_t strobe;
  logic       sending;
  logic       bitLast;

  cir_tx_control i_ctl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .startCtl(startCtl),
    .txEn(txEn), .fifoEmpty(fifoEmpty), .bitLast(bitLast),
    .strobe(strobe), .sending(sending), .fifoRd(fifoRd)
  );

  cir_tx_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .carTick(carTick), .dutySel(dutySel),
    .sending(sending), .strobe(strobe), .fifoRdata(fifoRdata),
    .bitLast(bitLast), .irOut(irOut), .txDoneIrq(txDoneIrq)
  );
endmodule

// File: rtl/cir_tx_checker.sv
module cir_tx_checker (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic txEn,
  input logic fifoEmpty,
  input logic fifoRd,
  input logic irOut,
  input logic txDoneIrq,
  input logic sending
);
  p_rd_needs_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> !fifoEmpty);
  p_rd_needs_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> txEn);
  p_irq_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    txDoneIrq |=> !txDoneIrq);
  p_irq_after_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    txDoneIrq |-> $past(bitTick));
  p_irq_not_after_pop_r7: assert property (@(posedge clk) disable iff (!rstN)
    txDoneIrq |-> !$past(fifoRd));
  p_out_only_sending_r9: assert property (@(posedge clk) disable iff (!rstN)
    irOut |-> sending);
endmodule

bind cir_tx_modulator cir_tx_checker u_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick), .txEn(txEn),
  .fifoEmpty(fifoEmpty), .fifoRd(fifoRd), .irOut(irOut),
  .txDoneIrq(txDoneIrq), .sending(sending)
);

// File: tb/test_cir_tx_modulator.sv
`timescale 1ns/1ps
module test_cir_tx_modulator;
  localparam int BP = 24;

  logic clk = 1'b0, rstN = 1'b0;
  logic bitTick = 1'b0, carTick = 1'b0, startCtl = 1'b0, txEn = 1'b0;
  logic [1:0] dutySel = 2'd0;
  logic fifoRd, irOut, txDoneIrq, fifoEmpty;
  logic [7:0] fifoRdata;

  logic [7:0] mem [16];
  int wp = 0, rp = 0;
  assign fifoEmpty = (wp == rp);
  assign fifoRdata = mem[rp[3:0]];

  int nChecks = 0, nFail = 0, cyc = 0, carDiv = 1, hiTotal = 0, irqSeen = 0;

  always #10 clk = ~clk;

  cir_tx_modulator i_cir_tx_modulator (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .carTick(carTick),
    .dutySel(dutySel), .startCtl(startCtl), .txEn(txEn),
    .fifoEmpty(fifoEmpty), .fifoRdata(fifoRdata), .fifoRd(fifoRd),
    .irOut(irOut), .txDoneIrq(txDoneIrq)
  );

  always @(posedge clk) if (rstN && fifoRd) rp <= rp + 1;

  // reference model from the requirements
  typedef enum int {M_IDLE, M_ARMED, M_SEND} mState_t;
  mState_t mState = M_IDLE;
  int mSub = 0, mIdx = 0;
  logic [7:0] mByte = 8'h00;
  logic mIrq = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mState <= M_IDLE; mSub <= 0; mIdx <= 0; mIrq <= 1'b0;
    end else begin
      mIrq <= 1'b0;
      if (carTick) mSub <= (mSub + 1) % 12;
      case (mState)
        M_IDLE: if (startCtl && txEn && !fifoEmpty) begin
          mByte <= mem[rp[3:0]]; mIdx <= 0; mState <= M_ARMED;
        end
        M_ARMED: if (bitTick) mState <= M_SEND;
        default: if (bitTick) begin
          if (mIdx < 7) mIdx <= mIdx + 1;
          else if (txEn && !fifoEmpty) begin mByte <= mem[rp[3:0]]; mIdx <= 0; end
          else begin mState <= M_IDLE; mIrq <= 1'b1; end
        end
      endcase
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  task automatic compareNow();
    logic eOut, eRd;
    eOut = (mState == M_SEND) && mByte[mIdx] && (mSub < 3 + int'(dutySel));
    eRd  = ((mState == M_IDLE) && startCtl && txEn && !fifoEmpty) ||
           ((mState == M_SEND) && bitTick && mIdx == 7 && txEn && !fifoEmpty);
    chk("R2 R3 R4 R6 R9 R10 irOut", irOut, eOut);
    chk("R5 R7 fifoRd", fifoRd, eRd);
    chk("R8 txDoneIrq", txDoneIrq, mIrq);
    if (irOut) hiTotal++;
    if (txDoneIrq) irqSeen++;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rstN) compareNow();
      cyc++;
      bitTick = (cyc % BP == 0);
      carTick = (cyc % carDiv == 0);
    end
  endtask

  task automatic push(input logic [7:0] b);
    mem[wp[3:0]] = b; wp++;
  endtask

  task automatic runFrame(input logic [7:0] b0, input logic [7:0] b1, input string tag);
    int ones, lim;
    ones = $countones(b0) + $countones(b1);
    hiTotal = 0; irqSeen = 0;
    push(b0); push(b1);
    startCtl = 1'b1; txEn = 1'b1;
    lim = 0;
    while (irqSeen == 0 && lim < 30 * BP) begin step(1); lim++; end
    startCtl = 1'b0;
    step(3);
    nChecks++;
    if (hiTotal != ones * 2 * (3 + int'(dutySel))) begin
      nFail++;
      $display("FAIL R2 %s: high cycles actual %0d expected %0d", tag, hiTotal,
               ones * 2 * (3 + int'(dutySel)));
    end
    nChecks++;
    if (irqSeen != 1) begin
      nFail++;
      $display("FAIL R8 %s: done pulses actual %0d expected 1", tag, irqSeen);
    end
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    step(4);
    // R1: reset state
    chk("R1 irOut", irOut, 1'b0);
    chk("R1 fifoRd", fifoRd, 1'b0);
    chk("R1 txDoneIrq", txDoneIrq, 1'b0);
    rstN = 1'b1;
    step(30);

    // duty and carrier rate sweep, with several byte patterns
    for (int d = 1; d <= 2; d++) begin
      carDiv = d;
      for (int k = 0; k < 4; k++) begin
        dutySel = 2'(k);
        runFrame(8'hFF, 8'hA5, "ones/alt");
        runFrame(8'h00, 8'h81, "zero pad");  // R3 padding byte
        runFrame(8'h01, 8'h7E, "lsb first"); // R4
      end
    end

    // R5: gating by start control and enable, R9: output stays low
    carDiv = 1;
    push(8'hFF);
    startCtl = 1'b0; txEn = 1'b1;
    for (int i = 0; i < 3 * BP; i++) begin
      step(1);
      chk("R5 no start without startCtl", fifoRd, 1'b0);
      chk("R9 idle low", irOut, 1'b0);
    end
    startCtl = 1'b1; txEn = 1'b0;
    for (int i = 0; i < 3 * BP; i++) begin
      step(1);
      chk("R5 no start without txEn", fifoRd, 1'b0);
      chk("R9 idle low", irOut, 1'b0);
    end
    txEn = 1'b1;
    hiTotal = 0; irqSeen = 0;
    step(11 * BP);
    startCtl = 1'b0;
    nChecks++;
    if (irqSeen != 1 || hiTotal != 8 * 2 * (3 + int'(dutySel))) begin
      nFail++;
      $display("FAIL R5 gated frame: pulses %0d high %0d expected 1 and %0d",
               irqSeen, hiTotal, 8 * 2 * (3 + int'(dutySel)));
    end

    // R8: txEn dropped at the byte boundary ends the frame despite data
    push(8'h0F); push(8'hF0);
    startCtl = 1'b1; txEn = 1'b1;
    step(5 * BP);
    txEn = 1'b0;
    startCtl = 1'b0;
    irqSeen = 0;
    step(6 * BP);
    nChecks++;
    if (irqSeen != 1 || fifoEmpty) begin
      nFail++;
      $display("FAIL R8 enable drop: pulses %0d empty %0b expected 1 and 0",
               irqSeen, fifoEmpty);
    end
    finishRun();
  end
endmodule